// File: doc/BRIEF.md
# Address Range Access Monitor

The monitor watches a processor's memory bus and decides, for every observed read or write, whether software has granted that kind of access to the addressed location. Six protection windows are programmed through a small register port. Each window is a naturally aligned, power-of-two sized region. A shared privilege word holds the permission bits, the enable and the test control. For each window it has one read permission bit and one write permission bit. It also has one catch-all permission bit for each direction.

When an access is refused, the monitor raises a one-cycle event on a read-violation or write-violation output, which an interrupt controller is expected to collect. It also records the refused address. The recorded address is the first one seen since software last released the record, and later refusals only pulse the event. Software releases the record by reading the violation register or by writing it. Stopping or aborting the offending bus cycle is outside this block.

Register slots on `cfg_idx`: 0 is the privilege word, 1 is the violation address, and 2 to 7 are windows 0 to 5. Window registers keep the aligned base in bits 31:9 and the size code in bits 4:0. Bits 8:5 read as zero.

Top module: `addr_guard`

## Requirements
- R1: After reset, every register slot reads zero and both event outputs are low.
- R2: While privilege bit 31 (enable) is clear, no access raises an event, whatever the permissions.
- R3: An address lies in window k when it agrees with the window base on all bits at and above the size code c, with 9 <= c <= 21. The window size is 2^c bytes, so code 9 is 512 bytes and code 21 is 2 MB. The last byte of a window is inside it, and the bytes just below and just above it are not.
- R4: A window whose size code is 0, or any value outside 9 to 21, contains no address and grants nothing.
- R5: Privilege bit k (0..5) lets window k be written, and bit 10+k lets window k be read. A permission for one direction grants nothing for the other.
- R6: Privilege bit 9 allows every write and bit 19 allows every read, with or without a matching window.
- R7: A refused read raises `rd_viol_evt`, and a refused write raises `wr_viol_evt`. The event appears in the cycle after the access is presented on the bus inputs and lasts one cycle. The two events are never high together.
- R8: The first refused address is captured in slot 1. While the record is held, later refusals do not overwrite it.
- R9: Reading slot 1 returns the record and releases it. Writing slot 1 loads the written value and releases it. The next refusal after a release is captured.
- R10: When the enable bit and privilege bit 30 (test) are both set, every access is refused regardless of permissions.
- R11: The privilege word keeps only bits 0-5, 9, 10-15, 19, 30 and 31, so writing all ones reads back as 0xC008FE3F. Writing all ones to a window slot reads back as 0xFFFFFE1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (releases the violation record when slot 1 is read) |
| cfg_idx | input | 3 | Register slot index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from the slot index |
| bus_valid | input | 1 | An access is present on the observed bus this cycle |
| bus_addr | input | 32 | Byte address of the observed access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| rd_viol_evt | output | 1 | One-cycle pulse for a refused read |
| wr_viol_evt | output | 1 | One-cycle pulse for a refused write |

## Verification
The assertions take for granted that `bus_write` and `bus_addr` are meaningful only while `bus_valid` is high. They also assume that software never writes and reads slot 1 in the same cycle. The bench drives the register port and the bus port in separate, non-overlapping cycles. It deasserts `bus_valid` between accesses, so each event can be tied to a single access. A register change therefore takes effect before the next access is presented.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    localparam int DATA_W    = 32;
    localparam int START_LSB = 9;
    localparam int CODE_W    = 5;

    // privilege word field positions (decoded by software, kept fixed)
    localparam int P_WR_BASE = 0;
    localparam int P_WR_ALL  = 9;
    localparam int P_RD_BASE = 10;
    localparam int P_RD_ALL  = 19;
    localparam int P_TEST    = 30;
    localparam int P_ENABLE  = 31;

    // register slots
    localparam int IDX_PRIV   = 0;
    localparam int IDX_VIOL   = 1;
    localparam int IDX_RANGE0 = 2;

    typedef struct packed {
        logic [DATA_W-1:START_LSB] base;
        logic [CODE_W-1:0]         code;
    } range_cfg_t;

    function automatic logic [DATA_W-1:0] priv_mask(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[P_WR_BASE + i] = 1'b1;
            m[P_RD_BASE + i] = 1'b1;
        end
        m[P_WR_ALL] = 1'b1;
        m[P_RD_ALL] = 1'b1;
        m[P_TEST]   = 1'b1;
        m[P_ENABLE] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/addr_guard_range.sv
module addr_guard_range
    import addr_guard_pkg::*;
#(
    parameter int CODE_MIN = 9,
    parameter int CODE_MAX = 21
) (
    input  range_cfg_t        cfg,
    input  logic [DATA_W-1:0] addr,
    output logic              hit
);
    logic              live;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] base_full;

    always_comb begin
        // R4: codes outside the legal span describe an empty window
        live      = (cfg.code >= CODE_W'(CODE_MIN)) && (cfg.code <= CODE_W'(CODE_MAX));
        keep      = {DATA_W{1'b1}} << cfg.code;
        base_full = {cfg.base, {START_LSB{1'b0}}};
        hit       = live && (((addr ^ base_full) & keep) == '0);
    end

endmodule

// File: rtl/addr_guard_check.sv
module addr_guard_check
    import addr_guard_pkg::*;
#(
    parameter int NUM_RANGES = 6
) (
    input  logic [DATA_W-1:0]     priv,
    input  logic [NUM_RANGES-1:0] hits,
    input  logic                  is_write,
    output logic                  refuse
);
    logic [NUM_RANGES-1:0] wr_perm;
    logic [NUM_RANGES-1:0] rd_perm;
    logic                  granted;
    logic                  unused_priv;

    always_comb begin
        wr_perm = priv[P_WR_BASE +: NUM_RANGES];
        rd_perm = priv[P_RD_BASE +: NUM_RANGES];
        if (is_write) begin
            granted = (|(hits & wr_perm)) || priv[P_WR_ALL];
        end else begin
            granted = (|(hits & rd_perm)) || priv[P_RD_ALL];
        end
        refuse      = priv[P_ENABLE] && (priv[P_TEST] || !granted);
        unused_priv = ^priv;
    end

endmodule

// File: rtl/addr_guard_regs.sv
module addr_guard_regs
    import addr_guard_pkg::*;
#(
    parameter int NUM_RANGES = 6,
    parameter int IDX_W      = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic                              cfg_rd,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [DATA_W-1:0]                 cfg_rdata,
    input  logic                              cap_req,
    input  logic [DATA_W-1:0]                 cap_addr,
    output logic [DATA_W-1:0]                 priv,
    output range_cfg_t [NUM_RANGES-1:0]       ranges
);
    localparam logic [DATA_W-1:0] PRIV_KEEP = priv_mask(NUM_RANGES);
    localparam int                GAP_W     = START_LSB - CODE_W;

    typedef struct packed {
        logic [DATA_W-1:0]            priv;
        logic [DATA_W-1:0]            viol;
        logic                         held;
        range_cfg_t [NUM_RANGES-1:0]  rng;
    } regs_t;

    regs_t st_d, st_q;
    logic  viol_wr;
    logic  viol_rd;

    always_comb begin
        viol_wr = cfg_wr && (cfg_idx == IDX_W'(IDX_VIOL));
        viol_rd = cfg_rd && (cfg_idx == IDX_W'(IDX_VIOL));
        st_d    = st_q;
        if (cfg_wr) begin
            if (cfg_idx == IDX_W'(IDX_PRIV)) begin
                st_d.priv = cfg_wdata & PRIV_KEEP;
            end
            if (viol_wr) begin
                st_d.viol = cfg_wdata;
            end
            for (int r = 0; r < NUM_RANGES; r++) begin
                if (cfg_idx == IDX_W'(IDX_RANGE0 + r)) begin
                    st_d.rng[r].base = cfg_wdata[DATA_W-1:START_LSB];
                    st_d.rng[r].code = cfg_wdata[CODE_W-1:0];
                end
            end
        end
        // R9: any software touch of the record releases it
        if (viol_wr || viol_rd) begin
            st_d.held = 1'b0;
        end
        // R8: only the first refusal since the last release is kept
        if (cap_req && !st_q.held && !viol_wr) begin
            st_d.viol = cap_addr;
            st_d.held = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_idx == IDX_W'(IDX_PRIV)) begin
            cfg_rdata = st_q.priv;
        end else if (cfg_idx == IDX_W'(IDX_VIOL)) begin
            cfg_rdata = st_q.viol;
        end
        for (int r = 0; r < NUM_RANGES; r++) begin
            if (cfg_idx == IDX_W'(IDX_RANGE0 + r)) begin
                cfg_rdata = {st_q.rng[r].base, {GAP_W{1'b0}}, st_q.rng[r].code};
            end
        end
        priv   = st_q.priv;
        ranges = st_q.rng;
    end

    // R8: a held record is not disturbed unless software touches slot 1
    a_r8_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !viol_wr && !viol_rd) |=> $stable(st_q.viol));

    // R8: a refusal arriving with the record free is recorded next cycle
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_req && !st_q.held && !viol_wr) |=> (st_q.viol == $past(cap_addr)) && st_q.held);

    // R9: reading the record without a new refusal frees it
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_rd && !cap_req) |=> !st_q.held);

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
#(
    parameter int NUM_RANGES = 6,     // at most 9: read and write bit groups must not collide
    parameter int CODE_MIN   = 9,
    parameter int CODE_MAX   = 21,
    localparam int IDX_W     = $clog2(NUM_RANGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic              bus_write,
    output logic              rd_viol_evt,
    output logic              wr_viol_evt
);
    typedef struct packed {
        logic rd;
        logic wr;
    } evt_t;

    evt_t                        ev_d, ev_q;
    logic [DATA_W-1:0]           priv;
    range_cfg_t [NUM_RANGES-1:0] ranges;
    logic [NUM_RANGES-1:0]       hits;
    logic                        refuse;
    logic                        cap_req;

    addr_guard_regs #(
        .NUM_RANGES (NUM_RANGES),
        .IDX_W      (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cap_req   (cap_req),
        .cap_addr  (bus_addr),
        .priv      (priv),
        .ranges    (ranges)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        addr_guard_range #(
            .CODE_MIN (CODE_MIN),
            .CODE_MAX (CODE_MAX)
        ) u_win (
            .cfg  (ranges[g]),
            .addr (bus_addr),
            .hit  (hits[g])
        );
    end

    addr_guard_check #(
        .NUM_RANGES (NUM_RANGES)
    ) u_check (
        .priv     (priv),
        .hits     (hits),
        .is_write (bus_write),
        .refuse   (refuse)
    );

    always_comb begin
        cap_req = bus_valid && refuse;
        ev_d.rd = cap_req && !bus_write;
        ev_d.wr = cap_req && bus_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign rd_viol_evt = ev_q.rd;
    assign wr_viol_evt = ev_q.wr;

    // R7: the two event lines never fire together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_viol_evt && wr_viol_evt));

    // R7: a read event always traces back to a read one cycle earlier
    a_r7_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
        rd_viol_evt |-> $past(bus_valid && !bus_write));

    // R7: a write event always traces back to a write one cycle earlier
    a_r7_wr_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_viol_evt |-> $past(bus_valid && bus_write));

    // R2: monitoring switched off means silence
    a_r2_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !priv[P_ENABLE]) |=> !(rd_viol_evt || wr_viol_evt));

    // R6: the catch-all read bit suppresses read events outside test mode
    a_r6_global_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && priv[P_RD_ALL] && !priv[P_TEST]) |=> !rd_viol_evt);

    // R10: test mode refuses every observed access
    a_r10_test_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && priv[P_ENABLE] && priv[P_TEST]) |=> (rd_viol_evt || wr_viol_evt));

endmodule

// File: tb/addr_guard_test.sv
module addr_guard_test;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, cfg_rd;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        bus_valid, bus_write;
    logic [31:0] bus_addr;
    logic        rd_viol_evt, wr_viol_evt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench-side model of the programmed state
    logic [31:0] m_priv;
    logic [31:0] m_base [N];
    logic [4:0]  m_code [N];
    logic [31:0] m_viol;
    bit          m_held;

    always #10 clk = ~clk;

    addr_guard uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_rd      (cfg_rd),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .bus_valid   (bus_valid),
        .bus_addr    (bus_addr),
        .bus_write   (bus_write),
        .rd_viol_evt (rd_viol_evt),
        .wr_viol_evt (wr_viol_evt)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] keep_mask();
        logic [31:0] m = 32'h0;
        for (int i = 0; i < N; i++) begin
            m[i]      = 1'b1;
            m[10 + i] = 1'b1;
        end
        m[9] = 1'b1; m[19] = 1'b1; m[30] = 1'b1; m[31] = 1'b1;
        return m;
    endfunction

    function automatic bit m_refuse(input logic [31:0] a, input bit wr);
        bit ok = wr ? m_priv[9] : m_priv[19];
        for (int r = 0; r < N; r++) begin
            if (m_code[r] >= 5'd9 && m_code[r] <= 5'd21 &&
                (((a ^ m_base[r]) >> m_code[r]) == 32'h0) &&
                m_priv[(wr ? 0 : 10) + r])
                ok = 1'b1;
        end
        return m_priv[31] && (m_priv[30] || !ok);
    endfunction

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx[2:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx == 0) m_priv = d & keep_mask();
        else if (idx == 1) begin m_viol = d; m_held = 1'b0; end
        else if (idx < N + 2) begin
            m_base[idx-2] = d & 32'hFFFF_FE00;
            m_code[idx-2] = d[4:0];
        end
    endtask

    task automatic cfg_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = idx[2:0];
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
        if (idx == 1) m_held = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input bit wr);
        bit exp = m_refuse(a, wr);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = wr;
        @(negedge clk);
        bus_valid = 1'b0;
        check(req, "events{rd,wr}", {30'h0, rd_viol_evt, wr_viol_evt},
              {30'h0, exp && !wr, exp && wr});
        if (exp && !m_held) begin m_viol = a; m_held = 1'b1; end
    endtask

    task automatic drain(input string req);
        logic [31:0] d;
        if (m_held) begin
            logic [31:0] e = m_viol;
            cfg_read(1, d);
            check(req, "violation address", d, e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cfg_wr = 0; cfg_rd = 0; cfg_idx = 0; cfg_wdata = 0;
        bus_valid = 0; bus_write = 0; bus_addr = 0;
        m_priv = 0; m_viol = 0; m_held = 0;
        for (int r = 0; r < N; r++) begin m_base[r] = 0; m_code[r] = 0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "events", {30'h0, rd_viol_evt, wr_viol_evt}, 32'h0);
        for (int i = 0; i < N + 2; i++) begin
            cfg_read(i, d);
            check("R1", "slot after reset", d, 32'h0);
        end

        // R2: disabled monitor stays quiet
        access("R2", 32'h0000_0000, 1'b0);
        access("R2", 32'hFFFF_FFFC, 1'b1);
        cfg_write(0, 32'h4000_0000);
        access("R2", 32'h1234_5678, 1'b0);

        // R11: readback layout
        cfg_write(0, 32'hFFFF_FFFF);
        cfg_read(0, d);
        check("R11", "privilege readback", d, 32'hC008_FE3F);
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_read(2, d);
        check("R11", "window readback", d, 32'hFFFF_FE1F);
        cfg_write(2, 32'h0);
        cfg_write(0, 32'h0);

        // R3/R5 sweep: every window, every legal code, each permission direction
        for (int r = 0; r < N; r++) begin
            for (int pm = 0; pm < 2; pm++) begin
                for (int c = 9; c <= 21; c++) begin
                    logic [31:0] b = 32'h8000_0000 | (32'(r) << 22);
                    logic [31:0] sz = 32'h1 << c;
                    cfg_write(r + 2, b | 32'(c));
                    cfg_write(0, 32'h8000_0000 | (pm == 0 ? (32'h1 << (10 + r)) : (32'h1 << r)));
                    for (int k = 0; k < 4; k++) begin
                        logic [31:0] a = (k == 0) ? b : (k == 1) ? b + sz - 1 :
                                         (k == 2) ? b + sz : b - 1;
                        for (int w = 0; w < 2; w++) begin
                            access("R3/R5", a, w[0]);
                            drain("R8/R9");
                        end
                    end
                end
                cfg_write(r + 2, 32'h0);
            end
        end

        // R4: empty or illegal size codes grant nothing
        cfg_write(0, 32'h8000_FC3F);
        for (int i = 0; i < 5; i++) begin
            logic [4:0] cv = (i == 0) ? 5'd0 : (i == 1) ? 5'd5 : (i == 2) ? 5'd8 :
                             (i == 3) ? 5'd22 : 5'd31;
            cfg_write(2, 32'h1000_0000 | 32'(cv));
            access("R4", 32'h1000_0000, 1'b0);
            access("R4", 32'h1000_0010, 1'b1);
            drain("R4");
        end
        cfg_write(2, 32'h1000_0009);
        access("R4", 32'h1000_0000, 1'b0);
        cfg_write(2, 32'h0);

        // R6: catch-all bits per direction
        cfg_write(0, 32'h8000_0200);
        access("R6", 32'h2222_0000, 1'b1);
        access("R6", 32'h2222_0000, 1'b0);
        drain("R6");
        cfg_write(0, 32'h8008_0000);
        access("R6", 32'h3333_0004, 1'b0);
        access("R6", 32'h3333_0004, 1'b1);
        drain("R6");

        // R10: test mode refuses even fully permitted accesses
        cfg_write(0, 32'hFFFF_FFFF);
        access("R10", 32'h4444_0000, 1'b0);
        access("R10", 32'h4444_0000, 1'b1);
        drain("R10");
        cfg_write(0, 32'h4008_0200);
        access("R10", 32'h4444_0000, 1'b1);

        // R7/R8: first refusal kept, second only pulses
        cfg_write(0, 32'h8000_0000);
        access("R7", 32'h5555_0000, 1'b0);
        access("R7", 32'h6666_0000, 1'b1);
        cfg_read(1, d);
        check("R8", "first refusal kept", d, 32'h5555_0000);
        cfg_read(1, d);
        check("R8", "record after release without refusal", d, 32'h5555_0000);
        access("R9", 32'h7777_0000, 1'b1);
        cfg_read(1, d);
        check("R9", "capture after read release", d, 32'h7777_0000);

        // R9: writing the record loads it and re-arms capture
        access("R9", 32'h8888_0000, 1'b0);
        cfg_write(1, 32'h0BAD_F00D);
        cfg_read(1, d);
        check("R9", "written record", d, 32'h0BAD_F00D);
        cfg_write(1, 32'h0000_0001);
        access("R9", 32'h9999_0000, 1'b0);
        cfg_read(1, d);
        check("R9", "capture after write release", d, 32'h9999_0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule